// File: doc/BRIEF.md
# Control Register AND Unit

This block holds two 8-bit control registers of a CPU core: the status byte, which carries the interrupt mask in bit 7 and the four arithmetic flags in bits 3..0, and an auxiliary control byte that only the later core variants have. It executes the AND-with-immediate instructions that target either register. It also carries out load and store requests that move a byte into or out of the auxiliary byte. Flags that other instructions produce arrive through a separate flag-write port.

The decoder looks at two instruction words. A first word whose high byte is 0x06 ANDs its low byte into the status byte. A first word of 0x0141 followed by a second word whose high byte is 0x06 ANDs the second word's low byte into the auxiliary byte. Only bits 7, 2, 1 and 0 of the auxiliary byte are stored. The other positions always read back as zero. The parameter `HAS_AUX` selects the earlier core variant (0) or the later one (1). With 0, the auxiliary byte is absent and its opcode is not recognised.

Top module: `ctlreg_and_unit`

## Requirements
- R1: After a synchronous reset the status byte reads 0x80 and the auxiliary byte reads 0x07.
- R2: When `ins_valid` is high and the high byte of `ins_w0` is 0x06, the status byte becomes its old value ANDed with `ins_w0[7:0]`. The flags sit at bit 3 (negative), bit 2 (zero), bit 1 (overflow) and bit 0 (carry), so the immediates 0xF7, 0xFB, 0xFD and 0xFE each clear exactly one flag.
- R3: Only auxiliary bits 7, 2, 1 and 0 are stored; a load of 0xFF reads back as 0x87, and the other positions always read zero.
- R4: When `ins_valid` is high, `ins_w0` is 0x0141 and the high byte of `ins_w1` is 0x06, the auxiliary byte is ANDed with `ins_w1[7:0]`. Starting from 0x87, the immediates 0x7F, 0x03, 0x01 and 0x00 give 0x07, 0x03, 0x01 and 0x00.
- R5: An AND into the auxiliary byte, or a load of it, leaves the status byte unchanged.
- R6: A flag write (`fw_en`) replaces status bits 3..0 with `fw_flags` in the following cycle and keeps bits 7..4.
- R7: When a flag write and an AND into the status byte happen in the same cycle, the AND result wins and the flag write is dropped.
- R8: With `HAS_AUX` = 0, the auxiliary opcode is not recognised, loads are ignored, the auxiliary byte reads 0x00, and the status byte is not affected by these requests.
- R9: `rd_byte` shows the auxiliary byte in the same cycle as `st_req` and is 0x00 when `st_req` is low.
- R10: A load and an auxiliary AND in the same cycle store the loaded value; the AND is dropped.
- R11: `ins_hit` is high in the same cycle that `ins_valid` carries a recognised opcode. It is low for any other word pair, such as the 0x0141 prefix followed by a second word whose high byte is not 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction words are valid this cycle |
| ins_w0 | input | 16 | First instruction word |
| ins_w1 | input | 16 | Second instruction word |
| ld_req | input | 1 | Load `ld_data` into the auxiliary byte |
| ld_data | input | 8 | Byte to load |
| st_req | input | 1 | Read out the auxiliary byte on `rd_byte` |
| fw_en | input | 1 | Flag write from the ALU |
| fw_flags | input | 4 | New negative, zero, overflow and carry flags (bits 3..0) |
| ins_hit | output | 1 | Opcode recognised |
| stat_q | output | 8 | Status byte |
| aux_q | output | 8 | Auxiliary byte |
| rd_byte | output | 8 | Read-back byte |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the default `HAS_AUX` = 1 and exercises the later variant: auxiliary masking, the AND sequence and the load-versus-AND priority. The other uses `HAS_AUX` = 0 and shows that the same auxiliary opcodes and loads fall through without touching either register. The default mask and reset values are kept, so the 0xFF-to-0x87 read-back and the 0x07 reset value can be checked directly.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int FLAG_W = 4;

    localparam logic [BYTE_W-1:0] OPC_AND    = 8'h06;
    localparam logic [WORD_W-1:0] PFX_AUX    = 16'h0141;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_AND_STAT = 2'd1,
        OP_AND_AUX  = 2'd2
    } ctl_op_e;

    typedef struct packed {
        ctl_op_e             op;
        logic [BYTE_W-1:0]   imm;
    } ctl_dec_t;

    function automatic logic [BYTE_W-1:0] masked_and(
        input logic [BYTE_W-1:0] a,
        input logic [BYTE_W-1:0] b,
        input logic [BYTE_W-1:0] m
    );
        return a & b & m;
    endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
    import ctlreg_pkg::*;
#(
    parameter bit HAS_AUX = 1'b1
) (
    input  logic                ins_valid,
    input  logic [WORD_W-1:0]   ins_w0,
    input  logic [WORD_W-1:0]   ins_w1,
    output ctl_dec_t            dec
);

    logic stat_match;
    logic aux_match;

    always_comb begin
        stat_match = ins_valid && (ins_w0[WORD_W-1:BYTE_W] == OPC_AND);
        aux_match  = HAS_AUX && ins_valid && (ins_w0 == PFX_AUX)
                     && (ins_w1[WORD_W-1:BYTE_W] == OPC_AND);
        dec.op  = OP_NONE;
        dec.imm = '0;
        if (stat_match) begin
            dec.op  = OP_AND_STAT;
            dec.imm = ins_w0[BYTE_W-1:0];
        end else if (aux_match) begin
            dec.op  = OP_AND_AUX;
            dec.imm = ins_w1[BYTE_W-1:0];
        end
    end

    // R11: a recognised aux op always carries the prefix
    always_comb begin
        if (dec.op == OP_AND_AUX)
            a_aux_prefix_r11: assert (ins_w0 == PFX_AUX);
    end

endmodule

// File: rtl/ctlreg_stat.sv
module ctlreg_stat
    import ctlreg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_VAL = 8'h80
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                and_en,
    input  logic [BYTE_W-1:0]   imm,
    input  logic                fw_en,
    input  logic [FLAG_W-1:0]   fw_flags,
    output logic [BYTE_W-1:0]   q
);

    logic [BYTE_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (and_en)
            nxt = masked_and(q, imm, '1);
        else if (fw_en)
            nxt = {q[BYTE_W-1:FLAG_W], fw_flags};
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= nxt;
    end

    p_and_result_r2: assert property (@(posedge clk) disable iff (rst)
        and_en |=> q == ($past(q) & $past(imm)));

    p_flag_write_r6: assert property (@(posedge clk) disable iff (rst)
        (fw_en && !and_en) |=> (q[FLAG_W-1:0] == $past(fw_flags))
                            && (q[BYTE_W-1:FLAG_W] == $past(q[BYTE_W-1:FLAG_W])));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!fw_en && !and_en) |=> $stable(q));

endmodule

// File: rtl/ctlreg_aux.sv
module ctlreg_aux
    import ctlreg_pkg::*;
#(
    parameter bit                HAS_AUX = 1'b1,
    parameter logic [BYTE_W-1:0] MASK    = 8'h87,
    parameter logic [BYTE_W-1:0] RST_VAL = 8'h07
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                and_en,
    input  logic [BYTE_W-1:0]   imm,
    input  logic                ld_en,
    input  logic [BYTE_W-1:0]   ld_data,
    input  logic                st_req,
    output logic [BYTE_W-1:0]   q,
    output logic [BYTE_W-1:0]   rd_byte
);

    localparam logic [BYTE_W-1:0] EFF_MASK = HAS_AUX ? MASK : '0;

    logic [BYTE_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (ld_en)
            nxt = ld_data & EFF_MASK;
        else if (and_en)
            nxt = masked_and(q, imm, EFF_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL & EFF_MASK;
        else     q <= nxt;
    end

    assign rd_byte = st_req ? q : '0;

    p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> q == ($past(ld_data) & EFF_MASK));

    p_and_seq_r4: assert property (@(posedge clk) disable iff (rst)
        (and_en && !ld_en) |=> q == ($past(q) & $past(imm)));

    generate
        if (!HAS_AUX) begin : g_absent
            p_absent_zero_r8: assert property (@(posedge clk) disable iff (rst)
                ld_en |=> q == '0);
        end
    endgenerate

endmodule

// File: rtl/ctlreg_and_unit.sv
module ctlreg_and_unit
    import ctlreg_pkg::*;
#(
    parameter bit                HAS_AUX  = 1'b1,
    parameter logic [7:0]        AUX_MASK = 8'h87,
    parameter logic [7:0]        AUX_RST  = 8'h07,
    parameter logic [7:0]        STAT_RST = 8'h80
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ins_valid,
    input  logic [15:0] ins_w0,
    input  logic [15:0] ins_w1,
    input  logic        ld_req,
    input  logic [7:0]  ld_data,
    input  logic        st_req,
    input  logic        fw_en,
    input  logic [3:0]  fw_flags,
    output logic        ins_hit,
    output logic [7:0]  stat_q,
    output logic [7:0]  aux_q,
    output logic [7:0]  rd_byte
);

    ctl_dec_t dec;
    logic     stat_and;
    logic     aux_and;
    logic     aux_ld;

    ctlreg_decode #(.HAS_AUX(HAS_AUX)) u_dec (
        .ins_valid (ins_valid),
        .ins_w0    (ins_w0),
        .ins_w1    (ins_w1),
        .dec       (dec)
    );

    assign stat_and = (dec.op == OP_AND_STAT);
    assign aux_and  = (dec.op == OP_AND_AUX);
    assign aux_ld   = HAS_AUX && ld_req;
    assign ins_hit  = (dec.op != OP_NONE);

    ctlreg_stat #(.RST_VAL(STAT_RST)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .and_en   (stat_and),
        .imm      (dec.imm),
        .fw_en    (fw_en),
        .fw_flags (fw_flags),
        .q        (stat_q)
    );

    ctlreg_aux #(
        .HAS_AUX (HAS_AUX),
        .MASK    (AUX_MASK),
        .RST_VAL (AUX_RST)
    ) u_aux (
        .clk     (clk),
        .rst     (rst),
        .and_en  (aux_and),
        .imm     (dec.imm),
        .ld_en   (aux_ld),
        .ld_data (ld_data),
        .st_req  (st_req),
        .q       (aux_q),
        .rd_byte (rd_byte)
    );

    p_aux_ops_keep_stat_r5: assert property (@(posedge clk) disable iff (rst)
        ((aux_and || aux_ld) && !fw_en && !stat_and) |=> $stable(stat_q));

    p_prio_and_over_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_and && fw_en) |=> stat_q == ($past(stat_q) & $past(ins_w0[7:0])));

    p_unimpl_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (aux_q & ~AUX_MASK) == 8'h00);

endmodule

// File: tb/ctlreg_and_unit_bench.sv
module ctlreg_and_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ins_valid;
    logic [15:0] ins_w0, ins_w1;
    logic        ld_req;
    logic [7:0]  ld_data;
    logic        st_req;
    logic        fw_en;
    logic [3:0]  fw_flags;
    logic        ins_hit, l_hit;
    logic [7:0]  stat_q, aux_q, rd_byte;
    logic [7:0]  l_stat, l_aux, l_rd;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    ctlreg_and_unit u_ctlreg_and_unit (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_w0(ins_w0),
        .ins_w1(ins_w1), .ld_req(ld_req), .ld_data(ld_data), .st_req(st_req),
        .fw_en(fw_en), .fw_flags(fw_flags), .ins_hit(ins_hit),
        .stat_q(stat_q), .aux_q(aux_q), .rd_byte(rd_byte)
    );

    ctlreg_and_unit #(.HAS_AUX(1'b0)) u_legacy (
        .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_w0(ins_w0),
        .ins_w1(ins_w1), .ld_req(ld_req), .ld_data(ld_data), .st_req(st_req),
        .fw_en(fw_en), .fw_flags(fw_flags), .ins_hit(l_hit),
        .stat_q(l_stat), .aux_q(l_aux), .rd_byte(l_rd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid = 0; ins_w0 = '0; ins_w1 = '0; ld_req = 0; ld_data = '0;
        st_req = 0; fw_en = 0; fw_flags = '0;
    endtask

    // drive at a falling edge, let one rising edge pass, return at next falling edge
    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    task automatic ins(input logic [15:0] w0, input logic [15:0] w1, input logic exp_hit);
        ins_valid = 1; ins_w0 = w0; ins_w1 = w1;
        #1 chk("R11 hit", {7'd0, ins_hit}, {7'd0, exp_hit});
        cycle();
    endtask

    task automatic t_reset();
        rst = 1; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1 stat", stat_q, 8'h80);
        chk("R1 aux", aux_q, 8'h07);
    endtask

    task automatic t_flags_and_stat();
        fw_en = 1; fw_flags = 4'hF; cycle();
        chk("R6 set all", stat_q, 8'h8F);
        ins(16'h06F7, 16'h0000, 1'b1); chk("R2 clr N", stat_q, 8'h87);
        ins(16'h06FB, 16'h0000, 1'b1); chk("R2 clr Z", stat_q, 8'h83);
        ins(16'h06FD, 16'h0000, 1'b1); chk("R2 clr V", stat_q, 8'h81);
        ins(16'h06FE, 16'h0000, 1'b1); chk("R2 clr C", stat_q, 8'h80);
        fw_en = 1; fw_flags = 4'hA; cycle();
        chk("R6 partial", stat_q, 8'h8A);
    endtask

    task automatic t_prio_flags();
        fw_en = 1; fw_flags = 4'h5;
        ins(16'h06F0, 16'h0000, 1'b1);
        chk("R7 and wins", stat_q, 8'h80);
        fw_en = 1; fw_flags = 4'hA; cycle();
        chk("R6 restore", stat_q, 8'h8A);
    endtask

    task automatic t_aux();
        ld_req = 1; ld_data = 8'hFF; cycle();
        chk("R3 load ff", aux_q, 8'h87);
        chk("R5 load keeps stat", stat_q, 8'h8A);
        st_req = 1; #1 chk("R9 readback", rd_byte, 8'h87);
        st_req = 0; #1 chk("R9 idle zero", rd_byte, 8'h00);
        ins(16'h0141, 16'h067F, 1'b1); chk("R4 and 7f", aux_q, 8'h07);
        chk("R5 stat kept", stat_q, 8'h8A);
        ins(16'h0141, 16'h0603, 1'b1); chk("R4 and 03", aux_q, 8'h03);
        ins(16'h0141, 16'h0601, 1'b1); chk("R4 and 01", aux_q, 8'h01);
        ins(16'h0141, 16'h0600, 1'b1); chk("R4 and 00", aux_q, 8'h00);
        chk("R5 stat still", stat_q, 8'h8A);
    endtask

    task automatic t_ld_prio();
        ld_req = 1; ld_data = 8'hFF;
        ins(16'h0141, 16'h0600, 1'b1);
        chk("R10 load wins", aux_q, 8'h87);
    endtask

    task automatic t_bad_prefix();
        ins(16'h0141, 16'h0700, 1'b0);
        chk("R11 aux untouched", aux_q, 8'h87);
        chk("R11 stat untouched", stat_q, 8'h8A);
    endtask

    task automatic t_legacy();
        logic [7:0] s0;
        s0 = l_stat;
        ins_valid = 1; ins_w0 = 16'h0141; ins_w1 = 16'h0600;
        #1 chk("R8 no hit", {7'd0, l_hit}, 8'h00);
        cycle();
        chk("R8 aux zero", l_aux, 8'h00);
        chk("R8 stat kept", l_stat, s0);
        ld_req = 1; ld_data = 8'hFF; cycle();
        chk("R8 load ignored", l_aux, 8'h00);
        st_req = 1; #1 chk("R8 readback zero", l_rd, 8'h00);
        cycle();
    endtask

    initial begin
        t_reset();
        t_flags_and_stat();
        t_prio_flags();
        t_aux();
        t_ld_prio();
        t_bad_prefix();
        t_legacy();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule